// File: doc/BRIEF.md
# Processor-Side Bus Grant Controller

This block sits inside a processor and decides when the processor hands its external bus to another master over a three-wire arbitration handshake. An outside device pulls a request line low. The processor answers by pulling its grant line low. The outside device then takes the bus by pulling an acknowledge line low, and it keeps the bus until it releases that line. Request and acknowledge come from outside the processor's clock domain, so they pass through a synchronizer before anything uses them. The synchronizer captures on falling clock edges.

The processor's own bus sequencer supplies two synchronous flags. One says the next bus cycle has been committed. The other says the address strobe for that cycle is being driven. When a cycle is committed but its strobe is not yet out, the grant is held back until the strobe appears, so that other devices see a cycle in progress. The block drives a "processor owns bus" flag back to the sequencer, and the sequencer may start a cycle only while that flag is high. If a request disappears before it is acknowledged, the grant is withdrawn and the processor keeps the bus. While another master holds the bus, a fresh request is granted again without giving the bus back to the processor in between. A short hold-off after each release keeps a late-falling request from the departing master from being granted a second time.

Top module: `bus_yield_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, `bus_grant_n` is 1 (grant negated) and `cpu_owns_bus` is 1.
- R2: A request (`bus_req_n` driven to 0) made while the processor owns the bus, and with no cycle that is committed but unstrobed (`cyc_committed`=0, or `strobe_driven`=1), drives `bus_grant_n` to 0 exactly SYNC_STAGES clock cycles after the input changes. `cpu_owns_bus` falls to 0 in the same cycle.
- R3: When a request is seen while `cyc_committed`=1 and `strobe_driven`=0, the grant stays negated and `cpu_owns_bus` stays 1 for as long as the strobe is absent. Once `strobe_driven` is sampled as 1, `bus_grant_n` goes to 0 on the next clock edge.
- R4: If a grant is asserted and has not been acknowledged, negating the request returns `bus_grant_n` to 1 and `cpu_owns_bus` to 1 exactly SYNC_STAGES cycles after the input change.
- R5: A request that is negated while the grant is being held back for the strobe never produces a grant, even when the strobe appears later. `cpu_owns_bus` stays 1.
- R6: Pulling `grant_ack_n` to 0 while the grant is asserted returns `bus_grant_n` to 1 exactly SYNC_STAGES cycles later. `cpu_owns_bus` stays 0 for every cycle that the synchronized acknowledge is still asserted.
- R7: After the acknowledge is released, with no request pending, `cpu_owns_bus` returns to 1 exactly SYNC_STAGES cycles after `grant_ack_n` rises.
- R8: Once the bus is released to another master, requests are ignored for REGRANT_HOLD cycles. If a request stays asserted throughout, `bus_grant_n` falls again exactly REGRANT_HOLD+1 cycles after it rose. A request that is negated no later than REGRANT_HOLD cycles after the acknowledge produces no second grant.
- R9: A new request made while another master holds the bus, after the hold-off has elapsed, asserts `bus_grant_n` SYNC_STAGES cycles later. `cpu_owns_bus` stays 0 through the old master's release, the new master's acknowledge and the new master's tenure. It returns to 1 only SYNC_STAGES cycles after the new master releases.
- R10: If such a re-grant is withdrawn while the old master still acknowledges, `bus_grant_n` returns to 1 SYNC_STAGES cycles later. `cpu_owns_bus` stays 0 until the acknowledge is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. Arbitration inputs are captured on the falling edge; all other state updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_req_n | input | 1 | Bus request from outside, active low, asynchronous |
| grant_ack_n | input | 1 | Grant acknowledge from the new master, active low, asynchronous |
| cyc_committed | input | 1 | Sequencer has committed to its next bus cycle (synchronous) |
| strobe_driven | input | 1 | Sequencer is driving the address strobe (synchronous) |
| bus_grant_n | output | 1 | Bus grant, active low |
| cpu_owns_bus | output | 1 | High while the sequencer may start bus cycles |

## Verification
The hardest situation to reach is a second grant while another master still holds the bus. The stimulus first has to complete a full grant and acknowledge. It then has to let the hold-off run out, and only then raise a new request while the old acknowledge is still low. The old acknowledge must then be released before the new one arrives. The bench walks through that sequence step by step, checking ownership at each handover. It also sweeps how late the departing master drops its request, to probe the edge of the hold-off window. A second sweep varies how long the strobe stays absent after a committed cycle, and each point is sampled exactly at the edge predicted from the synchronizer depth.

// File: rtl/bus_yield_pkg.sv
package bus_yield_pkg;

    typedef enum logic [2:0] {
        IDLE_OWNED        = 3'd0,
        WAIT_AS           = 3'd1,
        GRANTED           = 3'd2,
        RELEASED_TO_OTHER = 3'd3,
        REGRANT           = 3'd4
    } yield_state_e;

    // Synchronized arbitration inputs, converted to active-high.
    typedef struct packed {
        logic ack;
        logic req;
    } arb_in_t;

    function automatic logic grant_driven(yield_state_e s);
        return (s == GRANTED) || (s == REGRANT);
    endfunction

    function automatic logic cpu_holds(yield_state_e s);
        return (s == IDLE_OWNED) || (s == WAIT_AS);
    endfunction

endpackage

// File: rtl/bus_yield_sync.sv
module bus_yield_sync #(
    parameter int WIDTH = 2,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] IDLE_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] pipe_q [STAGES];

    // Falling-edge capture chain; the last stage is read on the rising edge.
    always_ff @(negedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe_q[i] <= IDLE_VAL;
        end else begin
            pipe_q[0] <= din;
            for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
        end
    end

    assign dout = pipe_q[STAGES-1];

endmodule

// File: rtl/bus_yield_fsm.sv
module bus_yield_fsm
    import bus_yield_pkg::*;
#(
    parameter int REGRANT_HOLD = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  arb_in_t arb,
    input  logic    cyc_committed,
    input  logic    strobe_driven,
    output logic    grant_n,
    output logic    owns
);

    localparam int HOLD_W = $clog2(REGRANT_HOLD + 1) + 1;
    localparam logic [HOLD_W-1:0] HOLD_MAX = HOLD_W'(REGRANT_HOLD);

    yield_state_e state_q, state_d;
    logic [HOLD_W-1:0] hold_q;
    logic hold_done;

    assign hold_done = (hold_q == HOLD_MAX);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IDLE_OWNED: begin
                if (arb.req) begin
                    if (cyc_committed && !strobe_driven) state_d = WAIT_AS;
                    else                                 state_d = GRANTED;
                end
            end
            WAIT_AS: begin
                if (!arb.req)                            state_d = IDLE_OWNED;
                else if (strobe_driven || !cyc_committed) state_d = GRANTED;
            end
            GRANTED: begin
                if (arb.ack)       state_d = RELEASED_TO_OTHER;
                else if (!arb.req) state_d = IDLE_OWNED;
            end
            RELEASED_TO_OTHER: begin
                if (arb.req && hold_done) state_d = REGRANT;
                else if (!arb.ack)        state_d = IDLE_OWNED;
            end
            REGRANT: begin
                if (!arb.ack)      state_d = GRANTED;
                else if (!arb.req) state_d = RELEASED_TO_OTHER;
            end
            default: state_d = IDLE_OWNED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= IDLE_OWNED;
        else     state_q <= state_d;
    end

    // Hold-off timer: restarts on every entry to the released state, saturates.
    always_ff @(posedge clk) begin
        if (rst || state_q != RELEASED_TO_OTHER) hold_q <= '0;
        else if (!hold_done)                     hold_q <= hold_q + 1'b1;
    end

    assign grant_n = !grant_driven(state_q);
    assign owns    = cpu_holds(state_q);

    a_r2_grant_needs_req: assert property (@(posedge clk) disable iff (rst)
        $fell(grant_n) |-> $past(arb.req));

    a_r3_hold_for_strobe: assert property (@(posedge clk) disable iff (rst)
        (state_q == IDLE_OWNED && arb.req && cyc_committed && !strobe_driven)
        |=> (grant_n && owns));

    a_r4_withdraw_returns_bus: assert property (@(posedge clk) disable iff (rst)
        (state_q == GRANTED && !arb.req && !arb.ack) |=> (grant_n && owns));

    a_r5_wait_withdraw: assert property (@(posedge clk) disable iff (rst)
        (state_q == WAIT_AS && !arb.req) |=> (grant_n && owns));

    a_r6_ack_drops_grant: assert property (@(posedge clk) disable iff (rst)
        (!grant_n && arb.ack && state_q != REGRANT) |=> grant_n);

    a_r6_owned_elsewhere: assert property (@(posedge clk) disable iff (rst)
        (!owns && arb.ack) |=> !owns);

    a_r8_holdoff: assert property (@(posedge clk) disable iff (rst)
        (state_q == RELEASED_TO_OTHER && hold_q < HOLD_MAX) |=> grant_n);

endmodule

// File: rtl/bus_yield_ctrl.sv
module bus_yield_ctrl
    import bus_yield_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int REGRANT_HOLD = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic bus_req_n,
    input  logic grant_ack_n,
    input  logic cyc_committed,
    input  logic strobe_driven,
    output logic bus_grant_n,
    output logic cpu_owns_bus
);

    localparam int ARB_W = $bits(arb_in_t);

    logic [ARB_W-1:0] raw_sync;
    arb_in_t          arb;

    bus_yield_sync #(
        .WIDTH    (ARB_W),
        .STAGES   (SYNC_STAGES),
        .IDLE_VAL ({ARB_W{1'b1}})
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({grant_ack_n, bus_req_n}),
        .dout (raw_sync)
    );

    assign arb = arb_in_t'(~raw_sync);

    bus_yield_fsm #(
        .REGRANT_HOLD (REGRANT_HOLD)
    ) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .arb           (arb),
        .cyc_committed (cyc_committed),
        .strobe_driven (strobe_driven),
        .grant_n       (bus_grant_n),
        .owns          (cpu_owns_bus)
    );

endmodule

// File: tb/bus_yield_ctrl_bench.sv
`timescale 1ns/1ps
module bus_yield_ctrl_bench;

    localparam int S = 2;
    localparam int H = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_req_n = 1'b1;
    logic grant_ack_n = 1'b1;
    logic cyc_committed = 1'b0;
    logic strobe_driven = 1'b0;
    logic bus_grant_n;
    logic cpu_owns_bus;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    bus_yield_ctrl #(.SYNC_STAGES(S), .REGRANT_HOLD(H)) u_bus_yield_ctrl (
        .clk           (clk),
        .rst           (rst),
        .bus_req_n     (bus_req_n),
        .grant_ack_n   (grant_ack_n),
        .cyc_committed (cyc_committed),
        .strobe_driven (strobe_driven),
        .bus_grant_n   (bus_grant_n),
        .cpu_owns_bus  (cpu_owns_bus)
    );

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(string tag, logic eg, logic eo);
        vectors++;
        if (bus_grant_n !== eg || cpu_owns_bus !== eo) begin
            fails++;
            $display("FAIL %s: grant_n=%b exp %b, owns=%b exp %b",
                     tag, bus_grant_n, eg, cpu_owns_bus, eo);
        end
    endtask

    task automatic settle();
        bus_req_n = 1'b1; grant_ack_n = 1'b1;
        cyc_committed = 1'b0; strobe_driven = 1'b0;
        step(S + H + 4);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        step(1);
        chk("R1 in reset", 1'b1, 1'b1);
        step(3);
        rst = 1'b0;
        step(1);
        chk("R1 after reset", 1'b1, 1'b1);
        step(2);

        // R2 / R4: immediate grant cases, then withdrawal before acknowledge
        for (int c = 0; c < 2; c++) begin
            for (int s = 0; s < 2; s++) begin
                if (!(c == 1 && s == 0)) begin
                    cyc_committed = c[0]; strobe_driven = s[0];
                    bus_req_n = 1'b0;
                    step(S - 1); chk("R2 before latency", 1'b1, 1'b1);
                    step(1);     chk("R2 grant at latency", 1'b0, 1'b0);
                    bus_req_n = 1'b1;
                    step(S - 1); chk("R4 before latency", 1'b0, 1'b0);
                    step(1);     chk("R4 withdrawn", 1'b1, 1'b1);
                    settle();
                end
            end
        end

        // R3: committed cycle, strobe late by d cycles
        for (int d = 0; d < 5; d++) begin
            cyc_committed = 1'b1; strobe_driven = 1'b0;
            bus_req_n = 1'b0;
            step(S);     chk("R3 held for strobe", 1'b1, 1'b1);
            step(d);     chk("R3 still held", 1'b1, 1'b1);
            strobe_driven = 1'b1;
            step(1);     chk("R3 grant after strobe", 1'b0, 1'b0);
            strobe_driven = 1'b0; cyc_committed = 1'b0;
            bus_req_n = 1'b1;
            step(S);     chk("R3 release", 1'b1, 1'b1);
            settle();
        end

        // R5: request dropped while waiting for the strobe
        cyc_committed = 1'b1; strobe_driven = 1'b0;
        bus_req_n = 1'b0;
        step(S + 2); chk("R5 waiting", 1'b1, 1'b1);
        bus_req_n = 1'b1;
        step(S);
        strobe_driven = 1'b1;
        step(1);     chk("R5 no grant", 1'b1, 1'b1);
        step(2);     chk("R5 no grant later", 1'b1, 1'b1);
        settle();

        // R6 / R7 / R8: acknowledge, with the requester dropping late by lag cycles
        for (int lag = 0; lag < S; lag++) begin
            bus_req_n = 1'b0;
            step(S);     chk("R6 granted", 1'b0, 1'b0);
            grant_ack_n = 1'b0;
            for (int k = 0; k < S; k++) begin
                if (k == lag) bus_req_n = 1'b1;
                if (k == S - 1) chk("R6 before ack seen", 1'b0, 1'b0);
                step(1);
            end
            chk("R6 grant off after ack", 1'b1, 1'b0);
            step(H + 3); chk("R8 no second grant", 1'b1, 1'b0);
            grant_ack_n = 1'b1;
            step(S - 1); chk("R7 still elsewhere", 1'b1, 1'b0);
            step(1);     chk("R7 bus returned", 1'b1, 1'b1);
            settle();
        end

        // R8: request held throughout, exact re-grant edge
        bus_req_n = 1'b0;
        step(S);     chk("R8 granted", 1'b0, 1'b0);
        grant_ack_n = 1'b0;
        step(S);     chk("R8 released", 1'b1, 1'b0);
        step(H);     chk("R8 hold-off", 1'b1, 1'b0);
        step(1);     chk("R8 regrant edge", 1'b0, 1'b0);
        bus_req_n = 1'b1; grant_ack_n = 1'b1;
        step(S + 2); chk("R8 back home", 1'b1, 1'b1);
        settle();

        // R9: second master during another's tenure
        bus_req_n = 1'b0;
        step(S);
        grant_ack_n = 1'b0; bus_req_n = 1'b1;
        step(S + H + 2); chk("R9 other holds bus", 1'b1, 1'b0);
        bus_req_n = 1'b0;
        step(S - 1); chk("R9 before latency", 1'b1, 1'b0);
        step(1);     chk("R9 regrant", 1'b0, 1'b0);
        grant_ack_n = 1'b1;
        step(S + 1); chk("R9 old master gone", 1'b0, 1'b0);
        grant_ack_n = 1'b0; bus_req_n = 1'b1;
        step(S);     chk("R9 new master acks", 1'b1, 1'b0);
        step(3);     chk("R9 new tenure", 1'b1, 1'b0);
        grant_ack_n = 1'b1;
        step(S - 1); chk("R9 before return", 1'b1, 1'b0);
        step(1);     chk("R9 returned", 1'b1, 1'b1);
        settle();

        // R10: re-grant withdrawn while old acknowledge still held
        bus_req_n = 1'b0;
        step(S);
        grant_ack_n = 1'b0; bus_req_n = 1'b1;
        step(S + H + 2);
        bus_req_n = 1'b0;
        step(S);     chk("R10 regrant", 1'b0, 1'b0);
        bus_req_n = 1'b1;
        step(S);     chk("R10 withdrawn", 1'b1, 1'b0);
        step(3);     chk("R10 still elsewhere", 1'b1, 1'b0);
        grant_ack_n = 1'b1;
        step(S);     chk("R10 returned", 1'b1, 1'b1);
        settle();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule